// File: doc/BRIEF.md
# Prefetch Burst Serializer with Burst Chop

The block sits on the read path of a prefetch-style memory. One wide core word arrives in a single clock. The block turns it into a burst of narrow beats on a double-data-rate data path. Each clock carries two beats, shown as two half-words per clock: the earlier beat and then the later beat. A full burst moves every slice of the word in four clocks. A chopped burst moves half the slices in two clocks.

A word is offered with a valid strobe, a chop flag and a start index. The start index rotates the beat order, so the burst begins at the selected slice and wraps around. A ready output keeps new words out while a burst is still running. Ready goes high again in the clock that carries the last pair of beats. A word accepted in that clock follows on with no idle beat between the two bursts.

Top module: `ddr_burst_serializer`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `out_valid` is 0, both beat outputs are 0 and `in_ready` is 1.
- R2: A word is accepted on a rising edge where `in_valid` and `in_ready` are both 1. Its first pair of beats is driven in the clock cycle that follows that edge.
- R3: With `in_chop` = 0, an accepted word produces 4 consecutive clock cycles of `out_valid`, which carry 8 beats.
- R4: With `in_chop` = 1, an accepted word produces 2 consecutive clock cycles of `out_valid`, which carry 4 beats.
- R5: Slice j of the word is bits [j*BEAT_W +: BEAT_W]. Beat k of a burst is slice (start + k) mod 8. In cycle p of the burst, `out_beat0` carries beat 2p and `out_beat1` carries beat 2p+1.
- R6: `in_ready` is 0 in every burst cycle except the last one. An `in_valid` pulse seen while `in_ready` is 0 is ignored and leaves the running burst unchanged.
- R7: A word accepted in the last cycle of a burst has its first pair in the very next cycle, so `out_valid` stays high across the boundary.
- R8: `out_valid` is 1 exactly in the cycles that carry beats. When it is 0, both beat outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | A core word is offered |
| in_word | input | BEAT_W*PREFETCH | Core word; slice 0 is the least significant |
| in_chop | input | 1 | 1 selects the half-length burst |
| in_start | input | $clog2(PREFETCH) | Index of the slice sent first |
| in_ready | output | 1 | A word can be accepted at this edge |
| out_valid | output | 1 | Beats are driven this cycle |
| out_beat0 | output | BEAT_W | Earlier beat of the clock |
| out_beat1 | output | BEAT_W | Later beat of the clock |

## Verification
The bench goes after the chop length. A design that miscounts chopped pairs would either stop after one cycle or run to four. It also goes after start indices near the wrap, where a rotation that does not take the modulus would pick the wrong slices or slices outside the word. Back-to-back bursts, with a chop next to a full burst, show up a controller that inserts an idle cycle or drops the first pair of the following word. Valid pulses in the middle of a burst would corrupt the running data if ready were decoded wrongly.

// File: rtl/burst_pkg.sv
package burst_pkg;

    typedef enum logic {
        MODE_FULL = 1'b0,
        MODE_CHOP = 1'b1
    } burst_mode_e;

    // index of the final clock (pair) of a burst for the given mode
    function automatic int final_pair(input burst_mode_e mode, input int pairs);
        return (mode == MODE_CHOP) ? (pairs / 2) - 1 : pairs - 1;
    endfunction

endpackage

// File: rtl/beat_mux.sv
module beat_mux #(
    parameter int BEAT_W = 8,
    parameter int SLICES = 8,
    localparam int IDX_W = $clog2(SLICES)
) (
    input  logic [BEAT_W*SLICES-1:0] word,
    input  logic [IDX_W-1:0]         idx,
    input  logic                     en,
    output logic [BEAT_W-1:0]        beat
);
    always_comb begin
        beat = '0;
        if (en) begin
            beat = word[idx*BEAT_W +: BEAT_W];
        end
    end
endmodule

// File: rtl/ddr_burst_serializer.sv
module ddr_burst_serializer #(
    parameter int BEAT_W   = 8,
    parameter int PREFETCH = 8,
    localparam int WORD_W  = BEAT_W * PREFETCH,
    localparam int IDX_W   = $clog2(PREFETCH),
    localparam int PAIRS   = PREFETCH / 2,
    localparam int PAIR_W  = IDX_W - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] in_word,
    input  logic              in_chop,
    input  logic [IDX_W-1:0]  in_start,
    output logic              in_ready,
    output logic              out_valid,
    output logic [BEAT_W-1:0] out_beat0,
    output logic [BEAT_W-1:0] out_beat1
);
    import burst_pkg::*;

    typedef struct packed {
        logic              active;
        logic [PAIR_W-1:0] pair;
        logic [PAIR_W-1:0] last;
        logic [IDX_W-1:0]  start;
        logic [WORD_W-1:0] word;
    } state_t;

    state_t st_d, st_q;
    logic   at_last;
    logic   accept;
    burst_mode_e mode;

    assign mode    = in_chop ? MODE_CHOP : MODE_FULL;
    assign at_last = st_q.pair == st_q.last;
    assign in_ready = !st_q.active || at_last;
    assign accept  = in_valid && in_ready;
    assign out_valid = st_q.active;

    always_comb begin
        st_d = st_q;
        if (accept) begin
            st_d.active = 1'b1;
            st_d.pair   = '0;
            st_d.last   = PAIR_W'(final_pair(mode, PAIRS));
            st_d.start  = in_start;
            st_d.word   = in_word;
        end else if (st_q.active) begin
            if (at_last) begin
                st_d.active = 1'b0;
            end else begin
                st_d.pair = st_q.pair + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    logic [BEAT_W-1:0] lane_beat [2];

    for (genvar lane = 0; lane < 2; lane++) begin : g_lane
        logic [IDX_W-1:0] idx;
        assign idx = st_q.start + {st_q.pair, 1'(lane)};
        beat_mux #(
            .BEAT_W(BEAT_W),
            .SLICES(PREFETCH)
        ) u_mux (
            .word(st_q.word),
            .idx (idx),
            .en  (st_q.active),
            .beat(lane_beat[lane])
        );
    end

    assign out_beat0 = lane_beat[0];
    assign out_beat1 = lane_beat[1];
endmodule

// File: rtl/burst_serializer_chk.sv
module burst_serializer_chk #(
    parameter int BEAT_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              in_chop,
    input logic              in_ready,
    input logic              out_valid,
    input logic [BEAT_W-1:0] out_beat0,
    input logic [BEAT_W-1:0] out_beat1
);
    p_first_pair_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> out_valid);

    p_full_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && !in_chop) |=> !in_ready ##1 !in_ready ##1 !in_ready ##1 (in_ready && out_valid));

    p_chop_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && in_chop) |=> !in_ready ##1 (in_ready && out_valid));

    p_busy_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !in_ready) |=> out_valid);

    p_idle_ready_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> in_ready);

    p_idle_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (out_beat0 == '0 && out_beat1 == '0));
endmodule

bind ddr_burst_serializer burst_serializer_chk #(.BEAT_W(BEAT_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_chop  (in_chop),
    .in_ready (in_ready),
    .out_valid(out_valid),
    .out_beat0(out_beat0),
    .out_beat1(out_beat1)
);

// File: tb/ddr_burst_serializer_test.sv
module ddr_burst_serializer_test;
    localparam int N = 8;
    localparam int P = 8;
    localparam int W = N * P;

    logic         clk = 0;
    logic         rst_n = 0;
    logic         in_valid = 0;
    logic [W-1:0] in_word = '0;
    logic         in_chop = 0;
    logic [2:0]   in_start = '0;
    logic         in_ready, out_valid;
    logic [N-1:0] out_beat0, out_beat1;

    int total = 0;
    int bad = 0;
    int vcnt = 0;
    bit done = 0;

    typedef struct { logic [N-1:0] lo; logic [N-1:0] hi; } pair_t;
    pair_t q[$];

    always #10 clk = ~clk;

    ddr_burst_serializer #(.BEAT_W(N), .PREFETCH(P)) uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_word(in_word),
        .in_chop(in_chop), .in_start(in_start), .in_ready(in_ready),
        .out_valid(out_valid), .out_beat0(out_beat0), .out_beat1(out_beat1)
    );

    function automatic logic [N-1:0] slice_of(input logic [W-1:0] w, input int k, input logic [2:0] s);
        int j = (int'(s) + k) % P;
        return w[j*N +: N];
    endfunction

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // called just after a falling edge: check, drive, advance to next falling edge
    task automatic step(input bit v, input logic [W-1:0] w, input bit c, input logic [2:0] s);
        bit exp_ready = (q.size() <= 1);
        bit exp_valid = (q.size() != 0);
        check(in_ready == exp_ready, "R6 ready", 64'(in_ready), 64'(exp_ready));
        check(out_valid == exp_valid, "R8 valid", 64'(out_valid), 64'(exp_valid));
        if (exp_valid) begin
            check(out_beat0 == q[0].lo, "R5 beat0", 64'(out_beat0), 64'(q[0].lo));
            check(out_beat1 == q[0].hi, "R5 beat1", 64'(out_beat1), 64'(q[0].hi));
            void'(q.pop_front());
        end else begin
            check(out_beat0 == '0 && out_beat1 == '0, "R8 idle data",
                  64'({out_beat0, out_beat1}), 64'(0));
        end
        if (out_valid) vcnt++;
        in_valid = v; in_word = w; in_chop = c; in_start = s;
        if (v && exp_ready) begin
            for (int p = 0; p < (c ? 2 : 4); p++) begin
                pair_t e;
                e.lo = slice_of(w, 2*p, s);
                e.hi = slice_of(w, 2*p + 1, s);
                q.push_back(e);
            end
        end
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(0, '0, 0, 3'd0);
    endtask

    function automatic logic [W-1:0] rnd_word();
        return {$urandom, $urandom};
    endfunction

    initial begin
        #4_000_000;
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        @(negedge clk);
        // R1: reset state, while held and after release
        check(out_valid == 0 && in_ready == 1, "R1 in reset", 64'({out_valid, in_ready}), 64'b01);
        @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check(out_valid == 0 && in_ready == 1 && out_beat0 == 0 && out_beat1 == 0,
              "R1 after reset", 64'({out_valid, in_ready}), 64'b01);

        // R3 full burst length, R2 first pair next cycle, R5 start 0
        vcnt = 0;
        step(1, 64'h7766554433221100, 0, 3'd0);
        check(out_valid == 1, "R2 first pair", 64'(out_valid), 64'd1);
        check(out_beat0 == 8'h00 && out_beat1 == 8'h11, "R5 slice order",
              64'({out_beat0, out_beat1}), 64'h0011);
        idle(6);
        check(vcnt == 4, "R3 full length", 64'(vcnt), 64'd4);

        // R4 chop length with wrap of start
        vcnt = 0;
        step(1, 64'h7766554433221100, 1, 3'd6);
        check(out_beat0 == 8'h66 && out_beat1 == 8'h77, "R4 chop pair0",
              64'({out_beat0, out_beat1}), 64'h6677);
        step(0, '0, 0, 3'd0);
        check(out_beat0 == 8'h00 && out_beat1 == 8'h11, "R4 chop wrap",
              64'({out_beat0, out_beat1}), 64'h0011);
        idle(4);
        check(vcnt == 2, "R4 chop length", 64'(vcnt), 64'd2);

        // R6 pulses mid-burst are ignored
        step(1, rnd_word(), 0, 3'd3);
        step(1, rnd_word(), 1, 3'd5);
        step(1, rnd_word(), 0, 3'd1);
        idle(6);
        check(q.size() == 0, "R6 ignored", 64'(q.size()), 64'd0);

        // R7 back-to-back: full, chop, chop, full with no gap
        vcnt = 0;
        step(1, rnd_word(), 0, 3'd7);
        idle(3);
        step(1, rnd_word(), 1, 3'd2);
        step(0, '0, 0, 3'd0);
        step(1, rnd_word(), 1, 3'd4);
        step(0, '0, 0, 3'd0);
        step(1, rnd_word(), 0, 3'd1);
        idle(6);
        check(vcnt == 12, "R7 no idle beat", 64'(vcnt), 64'd12);

        // random traffic
        for (int i = 0; i < 2000; i++) begin
            step(($urandom % 4) != 0, rnd_word(), $urandom % 2, 3'($urandom));
        end
        idle(6);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule